// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one short command against a serial flash device over a single data lane. A host writes a packed 32-bit control word; when that word has its execute bit set, the engine captures the address word and the two write-data words and then drives a frame on the serial pins. The frame is an opcode byte, then an optional address of one to four bytes, then optional write bytes (up to eight), then an optional run of dummy clocks, then an optional read of up to eight bytes. Read bytes come back packed into two 32-bit result words.

The serial pins follow clock mode 0: the select line goes low for the whole frame, the serial clock idles low, output data changes while the clock is low and input data is sampled as the clock rises. Every half period of the serial clock is paced by the `tick` strobe, so the bit rate is set by whoever drives that strobe. Control and status pins are plain levels and pulses: a busy level that is also readable as the in-progress bit of the control word, and a one-cycle `done` pulse when the frame ends. The block has no stream port, so there is no back-pressure: a control write while busy is simply dropped.

Top module: `flash_cmd_engine`

## Requirements
- R1: The control word fields are: bit 0 execute, bit 1 in-progress (read only), bits 11:7 dummy clock count, bits 14:12 write byte count minus one, bit 15 write enable, bits 17:16 address byte count minus one, bit 19 address enable, bits 22:20 read byte count minus one, bit 23 read enable, bits 31:24 opcode. A control write with bit 0 set while idle starts a command; on the next cycle `busy` is 1, `cs_n` is 0 and `ctrl_rdata` reads the written bits 31:2 with bit 1 = 1 and bit 0 = 0.
- R2: A count field of value k moves k+1 bytes (address 1 to 4, write and read 1 to 8); the dummy field gives the exact number of extra clocks. The frame has 8 + 8·(address bytes) + 8·(write bytes) + dummy + 8·(read bytes) rising serial clock edges.
- R3: Phases follow the fixed order opcode, address, write, dummy, read; a phase whose enable bit is 0 (or a dummy count of 0) is skipped entirely.
- R4: Every byte leaves on `mosi` most-significant bit first; the address is sent most-significant byte first, using bits 8n-1:0 of the address word for n address bytes (so three bytes use bits 23:0). `mosi` is 0 during dummy and read clocks.
- R5: Write bytes are sent from `wdata_lo` byte 0 (bits 7:0) upward, then from `wdata_hi` byte 0 upward; address and write words are captured in the cycle the command starts.
- R6: The first read byte lands in `rdata_lo` bits 7:0, the next in bits 15:8 and so on; bytes five to eight land in `rdata_hi` from bits 7:0 up. Each read byte is assembled from `miso` sampled at eight rising clock edges, first sample as bit 7.
- R7: Both result words are cleared when a command starts; bytes beyond the requested read count (all bytes when read is disabled) stay 0.
- R8: `cs_n` is low at every rising edge of `sck`; `sck` is low outside a frame and changes only in cycles where `tick` is 1; `mosi` does not change in the cycle `sck` rises.
- R9: A control write while `busy` is 1 is ignored: the stored control bits and the frame in flight are unchanged.
- R10: `done` is high for exactly one cycle, the cycle in which `busy` falls and `cs_n` returns high.
- R11: A control write with bit 0 clear stores the word (readable on `ctrl_rdata`) but starts nothing.
- R12: After reset `cs_n` is 1, `sck`, `mosi`, `busy`, `done` are 0, and `ctrl_rdata`, `rdata_lo`, `rdata_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-period pacing strobe for the serial clock |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word written by the host |
| addr_in | input | 32 | Command address word |
| wdata_lo | input | 32 | Write bytes 1 to 4 |
| wdata_hi | input | 32 | Write bytes 5 to 8 |
| ctrl_rdata | output | 32 | Stored control word with in-progress at bit 1 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rdata_lo | output | 32 | Read bytes 1 to 4 |
| rdata_hi | output | 32 | Read bytes 5 to 8 |
| cs_n | output | 1 | Flash select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A start is visible one cycle after the control write (busy, select and the in-progress bit), so the bench samples those at the next falling clock edge; after that each serial bit takes two `tick` strobes, which the bench randomizes, so every later result is due at a cycle the bench cannot fix in advance. The bench therefore waits for the `done` pulse and checks the whole frame there: the count of rising `sck` edges, the `mosi` bits it recorded at each rise against a stream built from the control word, and the two result words against bytes rebuilt from the `miso` bits it supplied, which must already be final in the `done` cycle. The bench drives each `miso` bit shortly after a rising edge so it is settled well before the next sample, and it checks that `done` has dropped one cycle later.

// File: rtl/fce_pkg.sv
package fce_pkg;

  localparam int CW_W      = 32;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int EXEC_BIT  = 0;
  localparam int BUSY_BIT  = 1;
  localparam int DUMMY_LSB = 7;
  localparam int DUMMY_W   = 5;
  localparam int CNT_W     = 3;
  localparam int WCNT_LSB  = 12;
  localparam int WEN_BIT   = 15;
  localparam int ACNT_LSB  = 16;
  localparam int ACNT_W    = 2;
  localparam int AEN_BIT   = 19;
  localparam int RCNT_LSB  = 20;
  localparam int REN_BIT   = 23;
  localparam int OPC_LSB   = 24;

  localparam int MAX_DATA_BYTES = 2 * WORD_W / BYTE_W;
  localparam int UNIT_W         = $clog2(MAX_DATA_BYTES);
  localparam int BITCNT_W       = DUMMY_W;
  localparam int STORE_W        = CW_W - 2;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_WR    = 3'd3,
    PH_DUMMY = 3'd4,
    PH_RD    = 3'd5
  } phase_t;

  typedef struct packed {
    logic               addr_en;
    logic [ACNT_W-1:0]  addr_cnt;
    logic               wr_en;
    logic [CNT_W-1:0]   wr_cnt;
    logic [DUMMY_W-1:0] dummy;
    logic               rd_en;
    logic [CNT_W-1:0]   rd_cnt;
  } cmd_cfg_t;

  function automatic cmd_cfg_t unpack_ctl(input logic [CW_W-1:0] w);
    cmd_cfg_t c;
    c.addr_en  = w[AEN_BIT];
    c.addr_cnt = w[ACNT_LSB +: ACNT_W];
    c.wr_en    = w[WEN_BIT];
    c.wr_cnt   = w[WCNT_LSB +: CNT_W];
    c.dummy    = w[DUMMY_LSB +: DUMMY_W];
    c.rd_en    = w[REN_BIT];
    c.rd_cnt   = w[RCNT_LSB +: CNT_W];
    return c;
  endfunction

  // Next enabled phase after ph; PH_IDLE means the frame ends.
  function automatic phase_t phase_after(input phase_t ph, input cmd_cfg_t c);
    phase_t r;
    r = PH_IDLE;
    if (ph == PH_OPC && c.addr_en)
      r = PH_ADDR;
    else if ((ph == PH_OPC || ph == PH_ADDR) && c.wr_en)
      r = PH_WR;
    else if ((ph == PH_OPC || ph == PH_ADDR || ph == PH_WR) && c.dummy != '0)
      r = PH_DUMMY;
    else if (ph != PH_RD && ph != PH_IDLE && c.rd_en)
      r = PH_RD;
    return r;
  endfunction

  // Number of units (bytes, or one dummy run) inside a phase.
  function automatic logic [UNIT_W:0] phase_units(input phase_t ph, input cmd_cfg_t c);
    logic [UNIT_W:0] n;
    case (ph)
      PH_ADDR: n = (UNIT_W+1)'(c.addr_cnt) + (UNIT_W+1)'(1);
      PH_WR:   n = (UNIT_W+1)'(c.wr_cnt) + (UNIT_W+1)'(1);
      PH_RD:   n = (UNIT_W+1)'(c.rd_cnt) + (UNIT_W+1)'(1);
      default: n = (UNIT_W+1)'(1);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/fce_ctl_reg.sv
module fce_ctl_reg
  import fce_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_wr,
  input  logic [CW_W-1:0]       ctrl_wdata,
  input  logic [WORD_W-1:0]     addr_in,
  input  logic [WORD_W-1:0]     wdata_lo,
  input  logic [WORD_W-1:0]     wdata_hi,
  input  logic                  busy,
  output logic                  start,
  output cmd_cfg_t              cfg,
  output logic [BYTE_W-1:0]     opcode,
  output logic [WORD_W-1:0]     addr_eff,
  output logic [2*WORD_W-1:0]   wdata_eff,
  output logic [STORE_W-1:0]    stored
);

  logic                  accept;
  logic [STORE_W-1:0]    ctl_q;
  logic [WORD_W-1:0]     addr_q;
  logic [2*WORD_W-1:0]   wd_q;
  logic [CW_W-1:0]       word_sel;
  logic                  unused_status_bit;

  assign unused_status_bit = ctrl_wdata[BUSY_BIT];

  // Writes are dropped while a frame runs.
  assign accept = ctrl_wr && !busy;
  assign start  = accept && ctrl_wdata[EXEC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      if (accept) ctl_q <= ctrl_wdata[CW_W-1:2];
      if (start) begin
        addr_q <= addr_in;
        wd_q   <= {wdata_hi, wdata_lo};
      end
    end
  end

  // In the start cycle the live inputs feed the first byte load.
  assign word_sel  = start ? ctrl_wdata : {ctl_q, 2'b00};
  assign cfg       = unpack_ctl(word_sel);
  assign opcode    = word_sel[OPC_LSB +: BYTE_W];
  assign addr_eff  = start ? addr_in : addr_q;
  assign wdata_eff = start ? {wdata_hi, wdata_lo} : wd_q;
  assign stored    = ctl_q;

endmodule

// File: rtl/fce_tx_select.sv
module fce_tx_select
  import fce_pkg::*;
(
  input  phase_t                ph,
  input  logic [UNIT_W-1:0]     unit,
  input  logic [BYTE_W-1:0]     opcode,
  input  logic [ACNT_W-1:0]     addr_cnt,
  input  logic [DUMMY_W-1:0]    dummy,
  input  logic [WORD_W-1:0]     addr,
  input  logic [2*WORD_W-1:0]   wdata,
  output logic [BYTE_W-1:0]     tx_byte,
  output logic [BITCNT_W-1:0]   bits_m1
);

  localparam int AIDX_W = ACNT_W + 3;
  localparam int WIDX_W = UNIT_W + 3;

  logic [ACNT_W-1:0] addr_sel;
  logic [AIDX_W-1:0] addr_idx;
  logic [WIDX_W-1:0] wr_idx;

  // Address goes out highest byte first: unit 0 picks byte addr_cnt.
  assign addr_sel = addr_cnt - unit[ACNT_W-1:0];
  assign addr_idx = {addr_sel, 3'b000};
  assign wr_idx   = {unit, 3'b000};

  always_comb begin
    tx_byte = '0;
    bits_m1 = BITCNT_W'(BYTE_W - 1);
    case (ph)
      PH_IDLE,
      PH_OPC:   tx_byte = opcode;
      PH_ADDR:  tx_byte = addr[addr_idx +: BYTE_W];
      PH_WR:    tx_byte = wdata[wr_idx +: BYTE_W];
      PH_DUMMY: bits_m1 = dummy - BITCNT_W'(1);
      default:  tx_byte = '0;
    endcase
  end

endmodule

// File: rtl/fce_rx_pack.sv
module fce_rx_pack
  import fce_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  shift_en,
  input  logic                  miso,
  input  logic                  store_en,
  input  logic [UNIT_W-1:0]     store_idx,
  output logic [2*WORD_W-1:0]   rdata
);

  logic [BYTE_W-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_sr <= '0;
    else if (shift_en) rx_sr <= {rx_sr[BYTE_W-2:0], miso};
  end

  for (genvar g = 0; g < MAX_DATA_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (clear)
        lane_q <= '0;
      else if (store_en && store_idx == UNIT_W'(g))
        lane_q <= rx_sr;
    end
    assign rdata[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/fce_sequencer.sv
module fce_sequencer
  import fce_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  start,
  input  cmd_cfg_t              cfg,
  input  logic [BYTE_W-1:0]     nxt_byte,
  input  logic [BITCNT_W-1:0]   nxt_bits_m1,
  output phase_t                nxt_phase,
  output logic [UNIT_W-1:0]     nxt_unit,
  output logic                  busy,
  output logic                  done,
  output logic                  cs_n,
  output logic                  sck,
  output logic                  mosi,
  output logic                  rx_shift,
  output logic                  rx_store,
  output logic [UNIT_W-1:0]     cur_unit
);

  phase_t                phase_q;
  logic [UNIT_W-1:0]     unit_q;
  logic [BITCNT_W-1:0]   bits_left_q;
  logic [BYTE_W-1:0]     tx_sr_q;
  logic                  sck_q, cs_n_q, busy_q, done_q;
  logic [UNIT_W:0]       units, unit_inc;
  logic                  last_unit, rise, fall, unit_end;

  assign units     = phase_units(phase_q, cfg);
  assign unit_inc  = {1'b0, unit_q} + (UNIT_W+1)'(1);
  assign last_unit = unit_inc >= units;

  always_comb begin
    if (phase_q == PH_IDLE) begin
      nxt_phase = PH_OPC;
      nxt_unit  = '0;
    end else if (!last_unit) begin
      nxt_phase = phase_q;
      nxt_unit  = unit_inc[UNIT_W-1:0];
    end else begin
      nxt_phase = phase_after(phase_q, cfg);
      nxt_unit  = '0;
    end
  end

  // sck itself marks which half of the bit period comes next.
  assign rise     = tick && busy_q && !sck_q;
  assign fall     = tick && busy_q && sck_q;
  assign unit_end = fall && (bits_left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      unit_q      <= '0;
      bits_left_q <= '0;
      tx_sr_q     <= '0;
      sck_q       <= 1'b0;
      cs_n_q      <= 1'b1;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q      <= 1'b1;
        cs_n_q      <= 1'b0;
        sck_q       <= 1'b0;
        phase_q     <= nxt_phase;
        unit_q      <= nxt_unit;
        tx_sr_q     <= nxt_byte;
        bits_left_q <= nxt_bits_m1;
      end else if (rise) begin
        sck_q <= 1'b1;
      end else if (fall) begin
        sck_q <= 1'b0;
        if (!unit_end) begin
          bits_left_q <= bits_left_q - BITCNT_W'(1);
          tx_sr_q     <= {tx_sr_q[BYTE_W-2:0], 1'b0};
        end else if (nxt_phase == PH_IDLE) begin
          busy_q  <= 1'b0;
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
          unit_q  <= '0;
          tx_sr_q <= '0;
        end else begin
          phase_q     <= nxt_phase;
          unit_q      <= nxt_unit;
          tx_sr_q     <= nxt_byte;
          bits_left_q <= nxt_bits_m1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign cs_n     = cs_n_q;
  assign sck      = sck_q;
  assign mosi     = tx_sr_q[BYTE_W-1];
  assign rx_shift = rise && (phase_q == PH_RD);
  assign rx_store = unit_end && (phase_q == PH_RD);
  assign cur_unit = unit_q;

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  input  logic [31:0] addr_in,
  input  logic [31:0] wdata_lo,
  input  logic [31:0] wdata_hi,
  output logic [31:0] ctrl_rdata,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdata_lo,
  output logic [31:0] rdata_hi,
  output logic        cs_n,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);

  logic                  start;
  cmd_cfg_t              cfg;
  logic [BYTE_W-1:0]     opcode;
  logic [WORD_W-1:0]     addr_eff;
  logic [2*WORD_W-1:0]   wdata_eff;
  logic [STORE_W-1:0]    stored;
  phase_t                nxt_phase;
  logic [UNIT_W-1:0]     nxt_unit, cur_unit;
  logic [BYTE_W-1:0]     nxt_byte;
  logic [BITCNT_W-1:0]   nxt_bits_m1;
  logic                  rx_shift, rx_store;
  logic [2*WORD_W-1:0]   rdata;

  fce_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .addr_in    (addr_in),
    .wdata_lo   (wdata_lo),
    .wdata_hi   (wdata_hi),
    .busy       (busy),
    .start      (start),
    .cfg        (cfg),
    .opcode     (opcode),
    .addr_eff   (addr_eff),
    .wdata_eff  (wdata_eff),
    .stored     (stored)
  );

  fce_tx_select u_tx (
    .ph       (nxt_phase),
    .unit     (nxt_unit),
    .opcode   (opcode),
    .addr_cnt (cfg.addr_cnt),
    .dummy    (cfg.dummy),
    .addr     (addr_eff),
    .wdata    (wdata_eff),
    .tx_byte  (nxt_byte),
    .bits_m1  (nxt_bits_m1)
  );

  fce_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .start       (start),
    .cfg         (cfg),
    .nxt_byte    (nxt_byte),
    .nxt_bits_m1 (nxt_bits_m1),
    .nxt_phase   (nxt_phase),
    .nxt_unit    (nxt_unit),
    .busy        (busy),
    .done        (done),
    .cs_n        (cs_n),
    .sck         (sck),
    .mosi        (mosi),
    .rx_shift    (rx_shift),
    .rx_store    (rx_store),
    .cur_unit    (cur_unit)
  );

  fce_rx_pack u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .shift_en  (rx_shift),
    .miso      (miso),
    .store_en  (rx_store),
    .store_idx (cur_unit),
    .rdata     (rdata)
  );

  assign ctrl_rdata = {stored, busy, 1'b0};
  assign rdata_lo   = rdata[WORD_W-1:0];
  assign rdata_hi   = rdata[2*WORD_W-1:WORD_W];

endmodule

// File: rtl/fce_checker.sv
module fce_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        ctrl_wr,
  input logic [31:0] ctrl_wdata,
  input logic [31:0] ctrl_rdata,
  input logic        busy,
  input logic        done,
  input logic [31:0] rdata_lo,
  input logic [31:0] rdata_hi,
  input logic        cs_n,
  input logic        sck,
  input logic        mosi
);

  // R1: an accepted execute write opens a frame on the next cycle
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[0] && !busy) |=> (busy && !cs_n));

  // R7: result words are zero in the cycle a command becomes busy
  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rdata_lo == 32'd0 && rdata_hi == 32'd0));

  // R8: clock high only inside a frame
  p_sck_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  // R8: clock moves only on a tick
  p_sck_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sck));

  // R8: data holds across the rising edge
  p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));

  // R9: writes during a frame leave the stored control bits alone
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy) |=> $stable(ctrl_rdata[31:2]));

  // R10: end pulse coincides with busy falling, select released
  p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && cs_n && !sck));

  // R10: the end pulse lasts a single cycle
  p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind flash_cmd_engine fce_checker u_fce_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .ctrl_wr    (ctrl_wr),
  .ctrl_wdata (ctrl_wdata),
  .ctrl_rdata (ctrl_rdata),
  .busy       (busy),
  .done       (done),
  .rdata_lo   (rdata_lo),
  .rdata_hi   (rdata_hi),
  .cs_n       (cs_n),
  .sck        (sck),
  .mosi       (mosi)
);

// File: tb/tb_flash_cmd_engine.sv
`timescale 1ns/1ps
module tb_flash_cmd_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] addr_in = '0;
  logic [31:0] wdata_lo = '0;
  logic [31:0] wdata_hi = '0;
  logic [31:0] ctrl_rdata;
  logic        busy, done, cs_n, sck, mosi;
  logic        miso = 1'b0;
  logic [31:0] rdata_lo, rdata_hi;

  int errors = 0;
  int checks = 0;
  int rises = 0;
  int frame_err = 0;
  int total_bits = 0;
  logic exp_bits [256];
  logic got_bits [256];
  logic miso_seq [256];

  flash_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .addr_in(addr_in), .wdata_lo(wdata_lo),
    .wdata_hi(wdata_hi), .ctrl_rdata(ctrl_rdata), .busy(busy), .done(done),
    .rdata_lo(rdata_lo), .rdata_hi(rdata_hi), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(1_600_000);
    chk(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
    summary();
    $finish;
  end

  // random pacing strobe
  initial forever begin
    @(negedge clk);
    tick = ($urandom % 4) != 0;
  end

  // flash side: record mosi at each rise, present next miso bit
  initial forever begin
    @(posedge sck);
    if (cs_n !== 1'b0) frame_err++;
    if (rises < 256) got_bits[rises] = mosi;
    rises++;
    #1 miso = miso_seq[rises & 255];
  end

  task automatic run_cmd(input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] lo, input logic [31:0] hi,
                         input bit poke, input string stag);
    int n, na, nw, nr, dm, pre, cyc, mism;
    logic [63:0] wd, exp_rd;
    n = 0; wd = {hi, lo}; exp_rd = '0;
    for (int i = 7; i >= 0; i--) begin exp_bits[n] = w[24+i]; n++; end
    if (w[19]) begin
      na = int'(w[17:16]) + 1;
      for (int k = na - 1; k >= 0; k--)
        for (int i = 7; i >= 0; i--) begin exp_bits[n] = a[8*k+i]; n++; end
    end
    if (w[15]) begin
      nw = int'(w[14:12]) + 1;
      for (int k = 0; k < nw; k++)
        for (int i = 7; i >= 0; i--) begin exp_bits[n] = wd[8*k+i]; n++; end
    end
    dm = int'(w[11:7]);
    for (int i = 0; i < dm; i++) begin exp_bits[n] = 1'b0; n++; end
    pre = n;
    nr = w[23] ? int'(w[22:20]) + 1 : 0;
    for (int i = 0; i < 8*nr; i++) begin exp_bits[n] = 1'b0; n++; end
    total_bits = n;
    for (int i = 0; i < 256; i++) miso_seq[i] = 1'($urandom % 2);
    for (int k = 0; k < nr; k++)
      for (int i = 0; i < 8; i++) exp_rd[8*k+7-i] = miso_seq[pre+8*k+i];

    @(negedge clk);
    rises = 0; frame_err = 0; miso = miso_seq[0];
    ctrl_wdata = w; addr_in = a; wdata_lo = lo; wdata_hi = hi; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    addr_in = $urandom; wdata_lo = $urandom; wdata_hi = $urandom;
    chk(busy === 1'b1 && cs_n === 1'b0, "R1", "start busy/cs_n",
        {62'd0, busy, cs_n}, 64'd2);
    chk(ctrl_rdata === {w[31:2], 2'b10}, "R1", "ctrl readback",
        {32'd0, ctrl_rdata}, {32'd0, w[31:2], 2'b10});
    if (poke) begin
      repeat (3) @(negedge clk);
      ctrl_wdata = ~w | 32'd1; ctrl_wr = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0;
      chk(ctrl_rdata === {w[31:2], 2'b10}, "R9", "write while busy",
          {32'd0, ctrl_rdata}, {32'd0, w[31:2], 2'b10});
    end
    cyc = 0;
    while (done !== 1'b1 && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R10", "done pulse seen", {63'd0, done}, 64'd1);
    chk(busy === 1'b0 && cs_n === 1'b1 && sck === 1'b0, "R8",
        "idle at done", {61'd0, busy, cs_n, sck}, 64'd2);
    chk(rises == total_bits, "R2", "sck rise count",
        64'(rises), 64'(total_bits));
    mism = 0;
    for (int i = 0; i < total_bits && i < 256; i++)
      if (got_bits[i] !== exp_bits[i]) mism++;
    chk(mism == 0, stag, "mosi stream mismatches", 64'(mism), 64'd0);
    chk({rdata_hi, rdata_lo} === exp_rd, "R6 R7", "read words",
        {rdata_hi, rdata_lo}, exp_rd);
    chk(frame_err == 0, "R8", "rise outside select", 64'(frame_err), 64'd0);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0 && busy === 1'b0 &&
        done === 1'b0, "R12", "reset pins", {59'd0, cs_n, sck, mosi, busy, done},
        64'h10);
    chk(ctrl_rdata === 32'd0 && rdata_lo === 32'd0 && rdata_hi === 32'd0,
        "R12", "reset words", {rdata_hi, rdata_lo | ctrl_rdata}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // opcode only
    run_cmd(32'hA5000001, 32'h0, 32'h0, 32'h0, 1'b0, "R3");
    // 4 address bytes + 8 write bytes
    run_cmd(32'h02_0B_F0_01, 32'hC1D2E3F4, 32'h44332211, 32'h88776655, 1'b0, "R5");
    // 3 address bytes, upper address byte must not appear
    run_cmd(32'h03_0A_00_01, 32'hFF123456, 32'h0, 32'h0, 1'b0, "R4");
    // 1 address byte
    run_cmd(32'h05_08_00_01, 32'h000000C3, 32'h0, 32'h0, 1'b0, "R4");
    // 8 read bytes
    run_cmd(32'h9F_F0_00_01, 32'h0, 32'h0, 32'h0, 1'b0, "R6");
    // 3 read bytes, upper bytes stay zero
    run_cmd(32'h9F_A0_00_01, 32'h0, 32'h0, 32'h0, 1'b0, "R7");
    // 31 dummy clocks then one read byte
    run_cmd(32'h6B_80_0F_81, 32'h0, 32'h0, 32'h0, 1'b0, "R3");
    // write while busy
    run_cmd(32'h3B_9B_A1_01, 32'h00ABCDEF, 32'h1234_5678, 32'h0, 1'b1, "R9");

    // R11: store without execute
    @(negedge clk);
    rises = 0;
    ctrl_wdata = 32'h77_9A_5A_80; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    repeat (30) @(negedge clk);
    chk(busy === 1'b0 && cs_n === 1'b1 && rises == 0, "R11", "no start",
        64'(rises), 64'd0);
    chk(ctrl_rdata === 32'h77_9A_5A_80, "R11", "stored word",
        {32'd0, ctrl_rdata}, 64'h779A5A80);

    for (int t = 0; t < 40; t++) begin
      w = $urandom;
      w[0] = 1'b1;
      run_cmd(w, $urandom, $urandom, $urandom, (t % 5) == 0, "R3");
    end

    summary();
    $finish;
  end

endmodule